// File: doc/BRIEF.md
# Pointer Address Generator

This block forms the memory address for a load or store that takes its address from a pointer register. It also produces the updated pointer when the addressing mode modifies it. The block holds thirty-two 32-bit pointers, arranged as two banks of sixteen.

A request names a pointer, a 3-bit mode, an access size and an optional displacement. In the same cycle the block returns the effective address. When the mode modifies the pointer, it also raises a writeback strobe and presents the new pointer value. That writeback is committed to the pointer file at the next clock edge.

A separate write port loads pointers from outside, for example from a result bus. When that port and the writeback hit the same pointer in the same cycle, the writeback takes precedence.

The displacement is scaled by the access size before it is used. When no displacement is given, it counts as one. All address arithmetic wraps modulo 2^32.

Top module: `ptr_agu`

## Requirements
- R1: The 32 pointers are selected by a 5-bit index: bit 4 picks the bank and bits 3:0 pick the entry. Reset clears every pointer to 0. An external write (`ext_we`) stores `ext_data` into pointer `ext_idx` at the next rising edge.
- R2: Mode 0 (plain indirect) gives `eff_addr` equal to the pointer value, and `wb_en` stays low.
- R3: Mode 1 (post-increment) and mode 2 (post-decrement) give `eff_addr` equal to the unmodified pointer. They raise `wb_en` with `wb_value` equal to the pointer plus (mode 1) or minus (mode 2) the scaled displacement.
- R4: Mode 3 (pre-increment) and mode 4 (pre-decrement) raise `wb_en`. `wb_value` is the pointer plus (mode 3) or minus (mode 4) the scaled displacement, and `eff_addr` equals that same updated value.
- R5: Mode 5 (offset) gives `eff_addr` equal to the pointer plus the scaled displacement, and `wb_en` stays low.
- R6: When `disp_vld` is 0, the displacement is taken as 1 whatever `disp` holds.
- R7: The displacement is multiplied by 1, 2 or 4 for `acc_size` codes 0 (byte), 1 (halfword) and 2 (word). Code 3 scales like a word.
- R8: Address and pointer arithmetic is 32-bit and wraps modulo 2^32 in both directions.
- R9: When the writeback and the external write target the same pointer in one cycle, the pointer takes `wb_value`. When they target different pointers, both are written.
- R10: Mode codes 6 and 7 behave exactly like mode 0.
- R11: `wb_en` is high only while `req_vld` is high. A raised `wb_en` stores `wb_value` into the requested pointer at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | A load/store address request is present |
| req_idx | input | 5 | Pointer index: bit 4 is the bank, bits 3:0 the entry |
| req_mode | input | 3 | Addressing mode code |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 word |
| disp_vld | input | 1 | Displacement supplied; when low, a displacement of 1 is used |
| disp | input | 5 | Unsigned displacement in access-size units |
| eff_addr | output | 32 | Effective address |
| wb_en | output | 1 | Pointer writeback strobe |
| wb_value | output | 32 | New pointer value for writeback |
| ext_we | input | 1 | External pointer write enable |
| ext_idx | input | 5 | External write pointer index |
| ext_data | input | 32 | External write data |

## Verification
The bench builds the block with its default parameters: two banks of sixteen 32-bit pointers and a 5-bit displacement. With these values the largest scaled step is 124, so directed cases that load pointers near 0 and near 2^32-1 exercise wrap in both directions. The full 5-bit index reaches both banks, including the entries at their edges. Random traffic also hits same-index collisions between the writeback and the external write, and drives the two unused mode codes.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  localparam logic [2:0] MD_PLAIN   = 3'd0;
  localparam logic [2:0] MD_POSTINC = 3'd1;
  localparam logic [2:0] MD_POSTDEC = 3'd2;
  localparam logic [2:0] MD_PREINC  = 3'd3;
  localparam logic [2:0] MD_PREDEC  = 3'd4;
  localparam logic [2:0] MD_OFFSET  = 3'd5;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_shift = 2'd0;
      SZ_HALF: size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ptr_agu_rst_sync.sv
module ptr_agu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 5
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [2:0]        mode,
  input  logic [1:0]        size,
  input  logic              disp_vld,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr,
  output logic              modifies,
  output logic [ADDR_W-1:0] new_ptr
);
  import ptr_agu_pkg::*;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] up_val;
  logic [ADDR_W-1:0] dn_val;

  always_comb begin
    step = disp_vld ? ADDR_W'(disp) : ADDR_W'(1);
    step = step << size_shift(size);
  end

  assign up_val = ptr + step;
  assign dn_val = ptr - step;

  always_comb begin
    addr     = ptr;
    modifies = 1'b0;
    new_ptr  = ptr;
    case (mode)
      MD_POSTINC: begin modifies = 1'b1; new_ptr = up_val; end
      MD_POSTDEC: begin modifies = 1'b1; new_ptr = dn_val; end
      MD_PREINC:  begin modifies = 1'b1; new_ptr = up_val; addr = up_val; end
      MD_PREDEC:  begin modifies = 1'b1; new_ptr = dn_val; addr = dn_val; end
      MD_OFFSET:  addr = up_val;
      default:    ;
    endcase
  end
endmodule

// File: rtl/ptr_agu_bank.sv
module ptr_agu_bank #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  localparam int SEL_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_en,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [ADDR_W-1:0] wb_data,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] regs_q [ENTRIES];
  logic [ADDR_W-1:0] regs_d [ENTRIES];
  logic              ld_en  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_comb begin
      ld_en[e]  = 1'b0;
      regs_d[e] = regs_q[e];
      if (wb_en && wb_sel == SEL_W'(e)) begin
        ld_en[e]  = 1'b1;
        regs_d[e] = wb_data;
      end else if (wr_en && wr_sel == SEL_W'(e)) begin
        ld_en[e]  = 1'b1;
        regs_d[e] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[e] <= '0;
      else if (ld_en[e]) regs_q[e] <= regs_d[e];
    end
  end

  assign rd_data = regs_q[rd_sel];

  AST_WB_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> regs_q[$past(wb_sel)] == $past(wb_data)); // R9
  AST_EXT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wb_en && wb_sel == wr_sel)) |=> regs_q[$past(wr_sel)] == $past(wr_data)); // R1
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int ADDR_W    = 32,
  parameter int BANKS     = 2,
  parameter int BANK_REGS = 16,
  parameter int DISP_W    = 5,
  localparam int NUM_PTRS = BANKS * BANK_REGS,
  localparam int IDX_W    = $clog2(NUM_PTRS),
  localparam int ENT_W    = $clog2(BANK_REGS),
  localparam int BANK_W   = IDX_W - ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [2:0]        req_mode,
  input  logic [1:0]        acc_size,
  input  logic              disp_vld,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [ADDR_W-1:0] ext_data
);
  import ptr_agu_pkg::*;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] bank_rd [BANKS];
  logic [ADDR_W-1:0] cur_ptr;
  logic              modifies;

  logic [BANK_W-1:0] req_bank;
  logic [BANK_W-1:0] ext_bank;
  assign req_bank = req_idx[IDX_W-1 -: BANK_W];
  assign ext_bank = ext_idx[IDX_W-1 -: BANK_W];

  ptr_agu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ptr_agu_bank #(
      .ADDR_W  (ADDR_W),
      .ENTRIES (BANK_REGS)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wb_en   (wb_en && req_bank == BANK_W'(b)),
      .wb_sel  (req_idx[ENT_W-1:0]),
      .wb_data (wb_value),
      .wr_en   (ext_we && ext_bank == BANK_W'(b)),
      .wr_sel  (ext_idx[ENT_W-1:0]),
      .wr_data (ext_data),
      .rd_sel  (req_idx[ENT_W-1:0]),
      .rd_data (bank_rd[b])
    );
  end

  assign cur_ptr = bank_rd[req_bank];

  ptr_agu_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_calc (
    .ptr      (cur_ptr),
    .mode     (req_mode),
    .size     (acc_size),
    .disp_vld (disp_vld),
    .disp     (disp),
    .addr     (eff_addr),
    .modifies (modifies),
    .new_ptr  (wb_value)
  );

  assign wb_en = req_vld && modifies;

  AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_mode == MD_PLAIN || req_mode > MD_OFFSET) |-> (!wb_en && eff_addr == cur_ptr)); // R10
  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_mode == MD_OFFSET) |-> !wb_en); // R5
  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_mode == MD_POSTINC || req_mode == MD_POSTDEC) |-> eff_addr == cur_ptr); // R3
  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_mode == MD_PREINC || req_mode == MD_PREDEC) |-> eff_addr == wb_value); // R4
  AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |-> !wb_en); // R11
endmodule

// File: tb/test_ptr_agu.sv
module test_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [4:0]  req_idx;
  logic [2:0]  req_mode;
  logic [1:0]  acc_size;
  logic        disp_vld;
  logic [4:0]  disp;
  logic [31:0] eff_addr;
  logic        wb_en;
  logic [31:0] wb_value;
  logic        ext_we;
  logic [4:0]  ext_idx;
  logic [31:0] ext_data;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  ptr_agu i_ptr_agu (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step_of(input logic [1:0] sz, input logic dv, input logic [4:0] d);
    logic [31:0] base = dv ? {27'd0, d} : 32'd1;
    case (sz)
      2'd0:    return base;
      2'd1:    return base * 2;
      default: return base * 4;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic cyc(input logic vld, input logic [4:0] idx, input logic [2:0] md,
                     input logic [1:0] sz, input logic dv, input logic [4:0] d,
                     input logic we, input logic [4:0] widx, input logic [31:0] wdat,
                     input string extra);
    logic [31:0] p, st, e_addr, e_new;
    logic e_wb;
    req_vld = vld; req_idx = idx; req_mode = md; acc_size = sz;
    disp_vld = dv; disp = d; ext_we = we; ext_idx = widx; ext_data = wdat;
    p  = model[idx];
    st = step_of(sz, dv, d);
    e_addr = p; e_new = p; e_wb = 1'b0;
    case (md)
      3'd1: begin e_wb = 1'b1; e_new = p + st; end
      3'd2: begin e_wb = 1'b1; e_new = p - st; end
      3'd3: begin e_wb = 1'b1; e_new = p + st; e_addr = e_new; end
      3'd4: begin e_wb = 1'b1; e_new = p - st; e_addr = e_new; end
      3'd5: e_addr = p + st;
      default: ;
    endcase
    e_wb = e_wb && vld;
    #1;
    check({tag_of(md), " addr ", extra}, eff_addr, e_addr);
    check({tag_of(md), " R11 wb_en ", extra}, {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) check({tag_of(md), " wb_value ", extra}, wb_value, e_new);
    @(posedge clk);
    if (we) model[widx] = wdat;
    if (e_wb) model[idx] = e_new;
    @(negedge clk);
  endtask

  task automatic load(input logic [4:0] idx, input logic [31:0] v);
    cyc(1'b0, idx, 3'd0, 2'd0, 1'b0, 5'd0, 1'b1, idx, v, "R1 load");
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < 32; i++)
      cyc(1'b0, 5'(i), 3'd0, 2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'd0, tag);
  endtask

  initial begin : watchdog
    int cnt = 0;
    while (!done && cnt < 100000) begin @(posedge clk); cnt++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst_n = 1'b0;
    req_vld = 0; req_idx = 0; req_mode = 0; acc_size = 0; disp_vld = 0; disp = 0;
    ext_we = 0; ext_idx = 0; ext_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    readback("R1 reset");

    // R1: both banks, edge entries
    load(5'd0, 32'h1000_0000); load(5'd15, 32'h2000_0000);
    load(5'd16, 32'h3000_0000); load(5'd31, 32'h4000_0000);
    readback("R1 banks");

    // R6: disp ignored when not valid; R7 scaling
    cyc(1, 5'd0, 3'd1, 2'd0, 1'b0, 5'd31, 0, 0, 0, "R6 default byte");
    cyc(1, 5'd0, 3'd1, 2'd1, 1'b0, 5'd7, 0, 0, 0, "R6 R7 default half");
    cyc(1, 5'd0, 3'd3, 2'd2, 1'b1, 5'd5, 0, 0, 0, "R7 word");
    cyc(1, 5'd0, 3'd3, 2'd3, 1'b1, 5'd5, 0, 0, 0, "R7 size3");
    cyc(1, 5'd15, 3'd5, 2'd1, 1'b1, 5'd31, 0, 0, 0, "R5 R7 offset half");

    // R8 wrap both ways
    load(5'd20, 32'hFFFF_FFFF);
    cyc(1, 5'd20, 3'd3, 2'd2, 1'b0, 5'd0, 0, 0, 0, "R8 wrap up");
    cyc(1, 5'd20, 3'd4, 2'd2, 1'b1, 5'd31, 0, 0, 0, "R8 wrap down");
    cyc(1, 5'd20, 3'd2, 2'd0, 1'b1, 5'd31, 0, 0, 0, "R8 post wrap");
    load(5'd21, 32'hFFFF_FFF0);
    cyc(1, 5'd21, 3'd5, 2'd2, 1'b1, 5'd31, 0, 0, 0, "R8 offset wrap");

    // R10 unused codes, R11 no writeback when idle
    cyc(1, 5'd16, 3'd6, 2'd2, 1'b1, 5'd3, 0, 0, 0, "R10 code6");
    cyc(1, 5'd16, 3'd7, 2'd2, 1'b1, 5'd3, 0, 0, 0, "R10 code7");
    cyc(0, 5'd31, 3'd1, 2'd2, 1'b1, 5'd3, 0, 0, 0, "R11 idle");

    // R9 collision: same index, then different indices
    cyc(1, 5'd31, 3'd1, 2'd0, 1'b1, 5'd2, 1, 5'd31, 32'hDEAD_BEEF, "R9 same idx");
    cyc(1, 5'd0, 3'd2, 2'd1, 1'b1, 5'd1, 1, 5'd17, 32'h5555_AAAA, "R9 diff idx");
    readback("R9 R11 state");

    seed_dummy = $urandom(32'd20240611);
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] ri, wi;
      logic       rwe;
      ri  = 5'($urandom % 32);
      rwe = ($urandom % 4) == 0;
      wi  = (($urandom % 3) == 0) ? ri : 5'($urandom % 32);
      cyc(($urandom % 8) != 0, ri, 3'($urandom % 8), 2'($urandom % 4),
          1'($urandom % 2), 5'($urandom % 32), rwe, wi,
          (($urandom % 4) == 0) ? 32'hFFFF_FFFF - ($urandom % 64) : $urandom, "rand");
    end
    readback("R1 R9 R11 final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule